// File: doc/BRIEF.md
# Multi-Scheme Test Address Sequencer

This block produces the order in which a memory row decoder is addressed during a test or aging workload. One of six address orders is chosen when a run is started. The orders are plain binary, reflected Gray and complement-paired, and each can run forward or in reverse. A run visits every one of the 2^N addresses exactly once. An internal step counter sets the position in the run, and each address is mapped from that counter without any further registers.

The current address is offered on a valid/ready output. `step_ready` is the advance strobe of the consumer. An address is consumed in a cycle where `addr_valid` and `step_ready` are both high. While `addr_valid` is high and `step_ready` is low, the offered address and wordline vector hold still; this is the back-pressure rule. From the same state the block drives the one-hot wordline vector that a row decoder would raise for the offered address. After the last address has been consumed, `run_done` pulses for one cycle and the block goes idle. A start request outranks everything else in its cycle.

Top module: `addr_seq_top`

## Requirements
- R1: The scheme code is captured only in a cycle where `run_start` is high. Codes are: 0 binary ascending, 1 binary descending, 2 Gray ascending, 3 Gray descending, 4 complement ascending, 5 complement descending. Codes 6 and 7 act as code 0. A change to `scheme_sel` during a run has no effect on that run.
- R2: Binary ascending offers 0, 1, … 2^N−1. Binary descending offers 2^N−1 down to 0.
- R3: Gray ascending offers c XOR (c>>1) for c = 0 … 2^N−1, so any two consecutive addresses differ in exactly one bit. Gray descending is the same list in reverse.
- R4: Complement ascending offers, at position k, the value k/2 when k is even and the bit-inverse of k/2 when k is odd (0, 31, 1, 30, … 15, 16 for N=5). Complement descending is that list in reverse (16, 15, 17, … 31, 0).
- R5: A cycle with `run_start` high makes the first address of the chosen scheme appear with `addr_valid` high after that clock edge, even mid-run. A consume request in the same cycle is ignored and `run_done` stays low.
- R6: While `addr_valid` is high and `step_ready` is low, `addr`, `addr_valid` and `wordline` keep their values.
- R7: Consuming the last address of a run raises `run_done` for exactly one cycle. From that edge on, `addr_valid` is low and all wordlines are low. While idle, `step_ready` has no effect.
- R8: While `addr_valid` is high, exactly one wordline is high, and its index equals `addr` (address 11111 raises wordline 31). While `addr_valid` is low, `wordline` is all zero and `addr` reads 0.
- R9: A synchronous reset with `rst_n` low clears the run: `addr_valid`, `run_done`, `addr` and `wordline` all read 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_start | input | 1 | Begin a new run with the scheme on `scheme_sel` |
| scheme_sel | input | 3 | Address order code, captured on `run_start` |
| step_ready | input | 1 | Consumer ready; advances the sequence when `addr_valid` is high |
| addr | output | ADDR_W | Offered address |
| addr_valid | output | 1 | Offered address is valid |
| run_done | output | 1 | One-cycle pulse after the last address is consumed |
| wordline | output | 2**ADDR_W | One-hot wordline for the offered address |

## Verification
Two events can meet in one cycle: a restart and the consumption of the final address. If the start did not take priority, the run would both finish and begin again, and `run_done` would pulse on top of a new run. The bench walks a complement run up to its last address and then raises `run_start` and `step_ready` together with a different scheme. It expects `run_done` to stay low and the first address of the new scheme to be offered. A restart is also combined with a consume in the middle of a run, and both results are compared with sequences the bench computes.

// File: rtl/asq_pkg.sv
package asq_pkg;

  typedef enum logic [2:0] {
    SCH_LIN_UP = 3'd0,
    SCH_LIN_DN = 3'd1,
    SCH_GRY_UP = 3'd2,
    SCH_GRY_DN = 3'd3,
    SCH_CMP_UP = 3'd4,
    SCH_CMP_DN = 3'd5
  } scheme_e;

  // Unused codes fall back to ascending binary.
  function automatic scheme_e scheme_decode(input logic [2:0] code);
    scheme_e s;
    case (code)
      3'd1:    s = SCH_LIN_DN;
      3'd2:    s = SCH_GRY_UP;
      3'd3:    s = SCH_GRY_DN;
      3'd4:    s = SCH_CMP_UP;
      3'd5:    s = SCH_CMP_DN;
      default: s = SCH_LIN_UP;
    endcase
    return s;
  endfunction

  function automatic logic scheme_is_reverse(input scheme_e s);
    return (s == SCH_LIN_DN) || (s == SCH_GRY_DN) || (s == SCH_CMP_DN);
  endfunction

endpackage

// File: rtl/asq_ctrl.sv
module asq_ctrl
  import asq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       scheme_in,
  input  logic             adv,
  output logic [CNT_W-1:0] count,
  output logic             valid,
  output logic             done,
  output scheme_e          scheme_q
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic consume;
  assign consume = valid && adv && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      valid    <= 1'b0;
      done     <= 1'b0;
      scheme_q <= SCH_LIN_UP;
    end else begin
      done <= 1'b0;
      if (start) begin
        scheme_q <= scheme_decode(scheme_in);
        count    <= '0;
        valid    <= 1'b1;
      end else if (consume) begin
        if (count == LAST) begin
          valid <= 1'b0;
          done  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  last_consume_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && count == LAST) |=> (done && !valid));

  // R1
  scheme_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(scheme_q));

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !adv && !start) |=> (valid && $stable(count)));

endmodule

// File: rtl/asq_map.sv
module asq_map
  import asq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] count,
  input  scheme_e           scheme,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] half;

  assign idx  = scheme_is_reverse(scheme) ? (LAST - count) : count;
  assign half = idx >> 1;

  always_comb begin
    case (scheme)
      SCH_GRY_UP, SCH_GRY_DN: addr = idx ^ (idx >> 1);
      SCH_CMP_UP, SCH_CMP_DN: addr = idx[0] ? ~half : half;
      default:                addr = idx;
    endcase
  end

endmodule

// File: rtl/asq_onehot.sv
module asq_onehot #(
  parameter int ADDR_W = 5,
  localparam int NWL   = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [NWL-1:0]    wl
);

  for (genvar g = 0; g < NWL; g++) begin : g_row
    localparam logic [ADDR_W-1:0] ROW = ADDR_W'(g);
    assign wl[g] = en && (addr == ROW);
  end

endmodule

// File: rtl/addr_seq_top.sv
module addr_seq_top
  import asq_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NWL   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic [2:0]        scheme_sel,
  input  logic              step_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic              run_done,
  output logic [NWL-1:0]    wordline
);

  logic [ADDR_W-1:0] count;
  logic [ADDR_W-1:0] mapped;
  scheme_e           scheme_q;

  asq_ctrl #(.CNT_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (run_start),
    .scheme_in (scheme_sel),
    .adv       (step_ready),
    .count     (count),
    .valid     (addr_valid),
    .done      (run_done),
    .scheme_q  (scheme_q)
  );

  asq_map #(.ADDR_W(ADDR_W)) u_map (
    .count  (count),
    .scheme (scheme_q),
    .addr   (mapped)
  );

  assign addr = addr_valid ? mapped : '0;

  asq_onehot #(.ADDR_W(ADDR_W)) u_wl (
    .addr (mapped),
    .en   (addr_valid),
    .wl   (wordline)
  );

  // R8
  wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ($countones(wordline) == 1 && wordline[addr]));

  // R3
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && step_ready && !run_start && !(&count) &&
     (scheme_q == SCH_GRY_UP || scheme_q == SCH_GRY_DN))
    |=> ($countones(addr ^ $past(addr)) == 1));

  // R6
  addr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !step_ready && !run_start) |=> ($stable(addr) && $stable(wordline)));

  // R5
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (addr_valid && !run_done));

endmodule

// File: tb/addr_seq_top_tb.sv
`timescale 1ns/1ps
module addr_seq_top_tb;

  localparam int W   = 5;
  localparam int N   = 1 << W;
  localparam int MSK = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start = 1'b0;
  logic [2:0] scheme_sel = 3'd0;
  logic step_ready = 1'b0;
  logic [W-1:0] addr;
  logic addr_valid;
  logic run_done;
  logic [N-1:0] wordline;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addr_seq_top #(.ADDR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .scheme_sel(scheme_sel),
    .step_ready(step_ready), .addr(addr), .addr_valid(addr_valid),
    .run_done(run_done), .wordline(wordline)
  );

  function automatic int ref_addr(input int code, input int k);
    int idx, h;
    bit dn;
    dn  = (code == 1) || (code == 3) || (code == 5);
    idx = dn ? (MSK - k) : k;
    h   = idx >> 1;
    case (code)
      2, 3:    return idx ^ (idx >> 1);
      4, 5:    return (idx % 2 == 1) ? ((~h) & MSK) : h;
      default: return idx;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_offer(input string req, input int exp);
    logic [N-1:0] wexp;
    wexp = '0;
    wexp[exp] = 1'b1;
    chk(addr_valid === 1'b1, {req, " valid"}, addr_valid, 1);
    chk(addr === W'(exp), {req, " addr"}, addr, exp);
    chk(wordline === wexp, "R8 wordline", wordline, wexp);
  endtask

  task automatic chk_idle(input string req);
    chk(addr_valid === 1'b0, {req, " valid low"}, addr_valid, 0);
    chk(wordline === '0, "R8 wordline idle", wordline, 0);
    chk(addr === '0, "R8 addr idle", addr, 0);
  endtask

  task automatic begin_run(input int code);
    run_start = 1'b1; scheme_sel = 3'(code); step_ready = 1'b0;
    tick();
    run_start = 1'b0;
  endtask

  // Full run with random stalls; optionally scramble scheme_sel mid-run.
  task automatic full_run(input int code, input bit scramble, input bit stop_before_last);
    int prev;
    string req;
    req = (code == 2 || code == 3) ? "R3" : (code == 4 || code == 5) ? "R4" :
          (code > 5) ? "R1" : "R2";
    begin_run(code);
    prev = -1;
    for (int k = 0; k < N; k++) begin
      int e;
      e = ref_addr(code, k);
      chk_offer(req, e);
      if ((code == 2 || code == 3) && prev >= 0)
        chk($countones(prev ^ int'(addr)) == 1, "R3 one-bit step", prev ^ int'(addr), 1);
      prev = int'(addr);
      if (stop_before_last && k == N - 1) return;
      for (int s = 0; s < int'($urandom % 3); s++) begin
        if (scramble) scheme_sel = 3'($urandom);
        tick();
        chk(addr === W'(e) && addr_valid === 1'b1, "R6 stall hold", addr, e);
      end
      if (scramble) scheme_sel = 3'($urandom);
      step_ready = 1'b1;
      tick();
      step_ready = 1'b0;
    end
    chk(run_done === 1'b1, "R7 done pulse", run_done, 1);
    chk_idle("R7");
    tick();
    chk(run_done === 1'b0, "R7 done one cycle", run_done, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0;
    tick(); tick();
    // R9 reset state
    chk(run_done === 1'b0, "R9 done reset", run_done, 0);
    chk_idle("R9");
    rst_n = 1'b1;
    tick();

    for (int c = 0; c < 6; c++) full_run(c, 1'b0, 1'b0);
    // R1 unused codes and mid-run scheme changes
    full_run(6, 1'b0, 1'b0);
    full_run(7, 1'b1, 1'b0);
    full_run(3, 1'b1, 1'b0);
    full_run(4, 1'b1, 1'b0);

    // R7 advance while idle is ignored
    step_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_idle("R7 idle adv");
      chk(run_done === 1'b0, "R7 idle no done", run_done, 0);
    end
    step_ready = 1'b0;

    // R5 start together with consume of last address
    full_run(4, 1'b0, 1'b1);
    run_start = 1'b1; step_ready = 1'b1; scheme_sel = 3'd1;
    tick();
    run_start = 1'b0; step_ready = 1'b0;
    chk(run_done === 1'b0, "R5 start beats done", run_done, 0);
    chk_offer("R5 restart", ref_addr(1, 0));
    tick();
    chk(run_done === 1'b0, "R5 no late done", run_done, 0);

    // R5 restart mid-run with consume
    step_ready = 1'b1; tick(); tick(); tick();
    run_start = 1'b1; scheme_sel = 3'd5;
    tick();
    run_start = 1'b0;
    chk_offer("R5 mid restart", ref_addr(5, 0));
    tick();
    chk_offer("R5 next after restart", ref_addr(5, 1));
    step_ready = 1'b0;

    // R9 reset mid-run
    rst_n = 1'b0;
    tick();
    chk(run_done === 1'b0, "R9 done mid reset", run_done, 0);
    chk_idle("R9 mid");
    rst_n = 1'b1;
    tick();
    chk_idle("R9 after");

    // Random mix of schemes
    for (int r = 0; r < 6; r++) full_run(int'($urandom % 8), 1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule